// File: doc/BRIEF.md
# Seconds Countdown Alarm with Interrupt

This block is a relative alarm timer. Software loads a 32-bit number of seconds, and the live count then steps down by one on each 1 Hz tick while counting is enabled. When the count steps from one to zero the block latches a sticky countdown-pending flag. That flag drives an interrupt request when its interrupt enable is set, and a wakeup output when the wakeup enable is set. Software clears the flag by writing 1 to its status bit.

A second, independent pending flag belongs to a wall-clock alarm. The calendar comparison that produces it lives elsewhere, and here it arrives only as a one-cycle strobe. The strobe is accepted only while the wall-clock alarm is enabled. That flag has its own interrupt enable and shares the single interrupt output.

All state sits behind a simple single-cycle register port: a write strobe with address and data, and a read-data output that is a combinational decode of the address.

Top module: `sec_alarm_ctrl`

## Requirements
- R1: After reset every register reads 0, and `irq` and `wake` are low.
- R2: A write to offset 0x20 stores the full 32-bit value, which reads back at 0x20, and loads the same value into the live count, which reads at 0x24 from the next cycle.
- R3: The live count falls by exactly one on each `tick_1hz` cycle while bit 0 at 0x28 is 1 and the count is non-zero. It does not change when that bit is 0 or when there is no tick.
- R4: When a tick takes the count from 1 to 0, bit 0 at 0x30 (countdown pending) becomes 1. The count then stays at 0 on further ticks and the flag is not set again.
- R5: Writing 0 to offset 0x20 stops a running countdown with the count at 0 and does not set the pending flag.
- R6: Writing a word with bit 0 = 1 to 0x30 clears the countdown pending flag. A write with bit 0 = 0 leaves it unchanged.
- R7: If a pending flag is set by hardware and cleared by software in the same cycle, it ends up set.
- R8: `irq` = (bit 0 at 0x30 AND bit 0 at 0x2C) OR (bit 0 at 0x4C AND bit 0 at 0x48).
- R9: `wake` = bit 0 at 0x30 AND bit 0 at 0x50. The wall-clock flag has no effect on it.
- R10: A `wall_hit` strobe sets bit 0 at 0x4C only while bit 0 at 0x44 is 1. Writing 1 to bit 0 at 0x4C clears the flag.
- R11: Reads of any unmapped offset return 0, and writes to one change no readable state.
- R12: A load write in the same cycle as an enabled tick wins: the count takes the written value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse, once per second |
| wall_hit | input | 1 | One-cycle strobe from the wall-clock match logic |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W (8) | Register byte offset |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Interrupt request |
| wake | output | 1 | Wakeup request |

## Verification
The assertions assume that `tick_1hz` and `wall_hit` are single-cycle pulses, and that the register port carries at most one write per cycle, with address and data steady during the write cycle. The bench drives every input on the falling clock edge. It raises each strobe for exactly one cycle and then returns it to 0, so each event is seen by exactly one rising edge. Where a test needs two events at once, such as a status clear together with the final tick, both are placed in the same one-cycle window.

// File: rtl/sa_pkg.sv
package sa_pkg;
   // byte offsets of the register window; software relies on these
   localparam int unsigned OFS_CD_LOAD  = 32'h20;
   localparam int unsigned OFS_CD_LIVE  = 32'h24;
   localparam int unsigned OFS_CD_EN    = 32'h28;
   localparam int unsigned OFS_CD_IE    = 32'h2C;
   localparam int unsigned OFS_CD_STAT  = 32'h30;
   localparam int unsigned OFS_WC_EN    = 32'h44;
   localparam int unsigned OFS_WC_IE    = 32'h48;
   localparam int unsigned OFS_WC_STAT  = 32'h4C;
   localparam int unsigned OFS_WAKE_EN  = 32'h50;
   localparam int unsigned OFS_HIGHEST  = OFS_WAKE_EN;

   // pending flag slots
   localparam int unsigned FLAG_CD = 0;
   localparam int unsigned FLAG_WC = 1;
   localparam int unsigned NUM_FLAGS = 2;

   typedef struct packed {
      logic cd_en;
      logic cd_ie;
      logic wc_en;
      logic wc_ie;
      logic wake_en;
   } sa_cfg_t;
endpackage

// File: rtl/sa_flag.sv
module sa_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set_i,
   input  logic clr_i,
   output logic pend_o
);
   logic pend_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pend_q <= 1'b0;
      else if (set_i)
         pend_q <= 1'b1;
      else if (clr_i)
         pend_q <= 1'b0;
   end

   assign pend_o = pend_q;

   // R7: a hardware set always lands, whatever software does that cycle
   p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      set_i |=> pend_q);

   // R6: a clear without a concurrent set empties the flag
   p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !set_i) |=> !pend_q);
endmodule

// File: rtl/sa_countdown.sv
module sa_countdown #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic             tick_i,
   input  logic             ld_i,
   input  logic [CNT_W-1:0] ld_val_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expire_o
);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             step;

   assign step     = en_i && tick_i && !ld_i && (cnt_q != '0);
   assign expire_o = step && (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (ld_i)
         cnt_q <= ld_val_i;
      else if (step)
         cnt_q <= cnt_q - ONE;
   end

   assign cnt_o = cnt_q;

   // R3: one second per enabled tick
   p_dec_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (en_i && tick_i && !ld_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

   // R4: an exhausted count stays exhausted until reloaded
   p_zero_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !ld_i) |=> (cnt_q == '0));

   // R4: the expiry pulse coincides with the step to zero
   p_expire_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
      expire_o |=> (cnt_q == '0));
endmodule

// File: rtl/sa_regs.sv
module sa_regs
   import sa_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 32
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   input  logic [CNT_W-1:0]     live_i,
   input  logic [NUM_FLAGS-1:0] pend_i,
   output sa_cfg_t              cfg_o,
   output logic                 ld_o,
   output logic [CNT_W-1:0]     ld_val_o,
   output logic [NUM_FLAGS-1:0] clr_o
);
   logic [CNT_W-1:0] load_q;
   sa_cfg_t          cfg_q;
   logic             hit_load, hit_cd_en, hit_cd_ie, hit_cd_st;
   logic             hit_wc_en, hit_wc_ie, hit_wc_st, hit_wake;

   assign hit_load  = (bus_addr == ADDR_W'(OFS_CD_LOAD));
   assign hit_cd_en = (bus_addr == ADDR_W'(OFS_CD_EN));
   assign hit_cd_ie = (bus_addr == ADDR_W'(OFS_CD_IE));
   assign hit_cd_st = (bus_addr == ADDR_W'(OFS_CD_STAT));
   assign hit_wc_en = (bus_addr == ADDR_W'(OFS_WC_EN));
   assign hit_wc_ie = (bus_addr == ADDR_W'(OFS_WC_IE));
   assign hit_wc_st = (bus_addr == ADDR_W'(OFS_WC_STAT));
   assign hit_wake  = (bus_addr == ADDR_W'(OFS_WAKE_EN));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         load_q <= '0;
         cfg_q  <= '0;
      end else if (bus_wr) begin
         if (hit_load)  load_q        <= bus_wdata[CNT_W-1:0];
         if (hit_cd_en) cfg_q.cd_en   <= bus_wdata[0];
         if (hit_cd_ie) cfg_q.cd_ie   <= bus_wdata[0];
         if (hit_wc_en) cfg_q.wc_en   <= bus_wdata[0];
         if (hit_wc_ie) cfg_q.wc_ie   <= bus_wdata[0];
         if (hit_wake)  cfg_q.wake_en <= bus_wdata[0];
      end
   end

   assign cfg_o    = cfg_q;
   assign ld_o     = bus_wr && hit_load;
   assign ld_val_o = bus_wdata[CNT_W-1:0];
   assign clr_o[FLAG_CD] = bus_wr && hit_cd_st && bus_wdata[0];
   assign clr_o[FLAG_WC] = bus_wr && hit_wc_st && bus_wdata[0];

   always_comb begin
      bus_rdata_mux = '0;
      if (hit_load)  bus_rdata_mux = DATA_W'(load_q);
      if (hit_cd_en) bus_rdata_mux = DATA_W'(cfg_q.cd_en);
      if (hit_cd_ie) bus_rdata_mux = DATA_W'(cfg_q.cd_ie);
      if (hit_cd_st) bus_rdata_mux = DATA_W'(pend_i[FLAG_CD]);
      if (hit_wc_en) bus_rdata_mux = DATA_W'(cfg_q.wc_en);
      if (hit_wc_ie) bus_rdata_mux = DATA_W'(cfg_q.wc_ie);
      if (hit_wc_st) bus_rdata_mux = DATA_W'(pend_i[FLAG_WC]);
      if (hit_wake)  bus_rdata_mux = DATA_W'(cfg_q.wake_en);
      if (bus_addr == ADDR_W'(OFS_CD_LIVE)) bus_rdata_mux = DATA_W'(live_i);
   end

   logic [DATA_W-1:0] bus_rdata_mux;
   logic [DATA_W-1:0] rdata_o_int;
   assign rdata_o_int = bus_rdata_mux;
endmodule

// File: rtl/sec_alarm_ctrl.sv
module sec_alarm_ctrl
   import sa_pkg::*;
#(
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned CNT_W   = 32,
   parameter bit          OUT_REG = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1hz,
   input  logic              wall_hit,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq,
   output logic              wake
);
   localparam int unsigned MIN_ADDR_W = $clog2(OFS_HIGHEST + 1);

   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("sec_alarm_ctrl: CNT_W must lie in 1..DATA_W");
   end
   if (ADDR_W < MIN_ADDR_W) begin : g_bad_addr_w
      $error("sec_alarm_ctrl: ADDR_W too narrow for the register window");
   end

   sa_cfg_t              cfg;
   logic                 ld;
   logic [CNT_W-1:0]     ld_val;
   logic [CNT_W-1:0]     live;
   logic                 expire;
   logic [NUM_FLAGS-1:0] pend;
   logic [NUM_FLAGS-1:0] clr;
   logic [NUM_FLAGS-1:0] set;
   logic                 irq_d, wake_d;

   sa_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) regs_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .live_i    (live),
      .pend_i    (pend),
      .cfg_o     (cfg),
      .ld_o      (ld),
      .ld_val_o  (ld_val),
      .clr_o     (clr)
   );

   assign bus_rdata = regs_i.rdata_o_int;

   sa_countdown #(.CNT_W(CNT_W)) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_i     (cfg.cd_en),
      .tick_i   (tick_1hz),
      .ld_i     (ld),
      .ld_val_i (ld_val),
      .cnt_o    (live),
      .expire_o (expire)
   );

   assign set[FLAG_CD] = expire;
   assign set[FLAG_WC] = wall_hit && cfg.wc_en;

   for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
      sa_flag flag_i (
         .clk    (clk),
         .rst_n  (rst_n),
         .set_i  (set[g]),
         .clr_i  (clr[g]),
         .pend_o (pend[g])
      );
   end

   assign irq_d  = (pend[FLAG_CD] && cfg.cd_ie) || (pend[FLAG_WC] && cfg.wc_ie);
   assign wake_d = pend[FLAG_CD] && cfg.wake_en;

   if (OUT_REG) begin : g_out_reg
      logic irq_q, wake_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_q  <= 1'b0;
            wake_q <= 1'b0;
         end else begin
            irq_q  <= irq_d;
            wake_q <= wake_d;
         end
      end
      assign irq  = irq_q;
      assign wake = wake_q;
   end else begin : g_out_comb
      assign irq  = irq_d;
      assign wake = wake_d;
   end

   // R2: a load write puts the written seconds into the live count
   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && bus_addr == ADDR_W'(OFS_CD_LOAD)) |=> (live == $past(bus_wdata[CNT_W-1:0])));

   // R10: with the wall alarm disabled, its strobe leaves a clear flag clear
   p_wall_gate_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wall_hit && !cfg.wc_en && !pend[FLAG_WC]) |=> !pend[FLAG_WC]);
endmodule

// File: tb/sec_alarm_ctrl_tb_top.sv
`timescale 1ns/1ps
module sec_alarm_ctrl_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_1hz = 1'b0;
   logic        wall_hit = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = 8'h00;
   logic [31:0] bus_wdata = 32'h0;
   logic [31:0] bus_rdata;
   logic        irq, wake;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sec_alarm_ctrl dut_i (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .wall_hit(wall_hit),
      .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq(irq), .wake(wake)
   );

   // load value, ticks applied, expected live count, expected pending
   localparam int NV = 6;
   localparam logic [31:0] V_LOAD [NV] = '{32'd5, 32'd3, 32'd2, 32'hFFFF_FFFF, 32'd1, 32'd0};
   localparam int          V_TICK [NV] = '{2, 3, 5, 1, 1, 3};
   localparam logic [31:0] V_LIVE [NV] = '{32'd3, 32'd0, 32'd0, 32'hFFFF_FFFE, 32'd0, 32'd0};
   localparam logic        V_PEND [NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d,
                      input logic t, input logic h);
      @(negedge clk);
      bus_wr = w; bus_addr = a; bus_wdata = d; tick_1hz = t; wall_hit = h;
      @(negedge clk);
      bus_wr = 1'b0; tick_1hz = 1'b0; wall_hit = 1'b0;
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      cyc(1'b1, a, d, 1'b0, 1'b0);
   endtask

   task automatic tk();
      cyc(1'b0, 8'h00, 32'h0, 1'b1, 1'b0);
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] v);
      bus_addr = a;
      #1;
      v = bus_rdata;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      logic [31:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      foreach (V_LOAD[i]) begin end
      rd(8'h20, v); chk("R1", "load", v, 0);
      rd(8'h24, v); chk("R1", "live", v, 0);
      rd(8'h28, v); chk("R1", "cd_en", v, 0);
      rd(8'h30, v); chk("R1", "cd_stat", v, 0);
      rd(8'h4C, v); chk("R1", "wc_stat", v, 0);
      rd(8'h50, v); chk("R1", "wake_en", v, 0);
      chk("R1", "irq", {31'b0, irq}, 0);
      chk("R1", "wake", {31'b0, wake}, 0);

      // table walk: R2, R3, R4, R5
      wr(8'h28, 32'h1);
      for (int i = 0; i < NV; i++) begin
         wr(8'h20, V_LOAD[i]);
         rd(8'h20, v); chk("R2", "load readback", v, V_LOAD[i]);
         for (int k = 0; k < V_TICK[i]; k++) tk();
         rd(8'h24, v); chk("R3", "live after ticks", v, V_LIVE[i]);
         rd(8'h30, v); chk("R4", "pending after ticks", v, {31'b0, V_PEND[i]});
         wr(8'h30, 32'h1);
      end

      // R3: no counting while disabled, none without a tick
      wr(8'h28, 32'h0);
      wr(8'h20, 32'd4);
      tk();
      rd(8'h24, v); chk("R3", "disabled tick", v, 32'd4);
      wr(8'h28, 32'h1);
      repeat (3) @(negedge clk);
      rd(8'h24, v); chk("R3", "no tick", v, 32'd4);
      tk();
      rd(8'h24, v); chk("R3", "one tick", v, 32'd3);

      // R4: pending set once only
      wr(8'h20, 32'd1);
      tk();
      rd(8'h30, v); chk("R4", "expiry sets", v, 1);
      wr(8'h30, 32'h1);
      tk(); tk();
      rd(8'h30, v); chk("R4", "no second set", v, 0);
      rd(8'h24, v); chk("R4", "stays zero", v, 0);

      // R5: zero load stops a running count
      wr(8'h20, 32'd10);
      tk();
      wr(8'h20, 32'd0);
      rd(8'h24, v); chk("R5", "zeroed", v, 0);
      tk();
      rd(8'h30, v); chk("R5", "no pending", v, 0);

      // R6: W1C semantics
      wr(8'h20, 32'd1); tk();
      wr(8'h30, 32'hFFFF_FFFE);
      rd(8'h30, v); chk("R6", "write 0 keeps", v, 1);
      wr(8'h30, 32'h1);
      rd(8'h30, v); chk("R6", "write 1 clears", v, 0);

      // R7: set beats clear in the same cycle (flag already set beforehand)
      wr(8'h20, 32'd1); tk();
      wr(8'h20, 32'd1);
      cyc(1'b1, 8'h30, 32'h1, 1'b1, 1'b0);
      rd(8'h30, v); chk("R7", "set wins", v, 1);

      // R8 / R9 with countdown pending = 1
      chk("R8", "irq ie off", {31'b0, irq}, 0);
      wr(8'h2C, 32'h1);
      chk("R8", "irq ie on", {31'b0, irq}, 1);
      chk("R9", "wake en off", {31'b0, wake}, 0);
      wr(8'h50, 32'h1);
      chk("R9", "wake en on", {31'b0, wake}, 1);
      wr(8'h30, 32'h1);
      chk("R8", "irq after clear", {31'b0, irq}, 0);
      chk("R9", "wake after clear", {31'b0, wake}, 0);
      wr(8'h2C, 32'h0);

      // R10: wall-clock gating and W1C
      cyc(1'b0, 8'h00, 32'h0, 1'b0, 1'b1);
      rd(8'h4C, v); chk("R10", "hit while disabled", v, 0);
      wr(8'h44, 32'h1);
      cyc(1'b0, 8'h00, 32'h0, 1'b0, 1'b1);
      rd(8'h4C, v); chk("R10", "hit while enabled", v, 1);
      chk("R8", "wall irq ie off", {31'b0, irq}, 0);
      chk("R9", "wall no wake", {31'b0, wake}, 0);
      wr(8'h48, 32'h1);
      chk("R8", "wall irq ie on", {31'b0, irq}, 1);
      wr(8'h4C, 32'h1);
      rd(8'h4C, v); chk("R10", "wall clear", v, 0);
      chk("R8", "irq after wall clear", {31'b0, irq}, 0);

      // R11: unmapped offsets
      wr(8'h34, 32'hDEAD_BEEF);
      rd(8'h34, v); chk("R11", "unmapped read", v, 0);
      rd(8'h40, v); chk("R11", "unmapped read 2", v, 0);
      rd(8'h28, v); chk("R11", "enable untouched", v, 1);

      // R12: load beats a concurrent tick
      wr(8'h20, 32'd9);
      cyc(1'b1, 8'h20, 32'd7, 1'b1, 1'b0);
      rd(8'h24, v); chk("R12", "load wins", v, 32'd7);

      finish_run();
   end
endmodule